// File: doc/BRIEF.md
# Peer Doorbell Vector Table

This block tracks the remote members of a shared-memory group and how many doorbell vectors each has registered. A stream of membership messages comes in on a valid/ready handshake. Each message carries a signed peer position and a bit saying whether a notification channel came with it. The messages teach the node its own identifier, register vectors against peers, tear peers down, and announce the shared region. The block also keeps the highest active peer position.

A separate doorbell request port takes a destination and a vector. A legal request produces a one-cycle notify pulse, registered, that names the destination and the vector. An illegal request is dropped without a trace.

The control is a two-state machine:
- **ST_CLEAR** is entered on reset. It zeroes one table entry per cycle while `msg_ready` is low.
- **ST_ACTIVE** is entered after the last entry is swept. The block stays there until the next reset.

A combinational decoder sorts every accepted message into one of these kinds:
- MK_IDENT
- MK_DROP_PEER
- MK_REGION
- MK_APPEND
- MK_FULL
- MK_BADPOS

When no message is accepted, the kind is MK_NONE.

Top module: `peer_doorbell_table`

## Requirements
- R1: Reset state.
  - While reset is held, `self_id` is -1 (all ones), `max_peer` is 0, and `notify_valid`, `pos_err` and `ovf_err` are 0.
  - For exactly NUM_PEERS clock edges after reset is released, `msg_ready` is 0. Messages and doorbells offered in that time are ignored.
  - After that, `msg_ready` is 1 and stays 1.
- R2: Learning the node identifier. An accepted message has no channel (`msg_has_handle`=0), a position p in 0..NUM_PEERS-1, and peer p holds zero vectors. Then `self_id` becomes p on the next cycle and nothing else changes.
- R3: Peer teardown. An accepted message without a channel for a position whose peer holds one or more vectors clears that peer's count to 0. `self_id` and `max_peer` are left unchanged.
- R4: Region announcement. An accepted message with a channel and position -1 sets `max_peer` to 0 and registers nothing. Vector counts already held are kept.
- R5: Vector registration. An accepted message with a channel and a position p in 0..NUM_PEERS-1 adds one vector to peer p, as long as the peer holds fewer than NUM_VECTORS. The new vector's index equals the count before the addition, so after k additions vectors 0..k-1 are forwardable.
- R6: Highest peer. `max_peer` takes the value p when a registration under R5 uses a position above the current value. Apart from R4 and reset, it never changes otherwise.
- R7: Bad positions. A message raises `pos_err` for one cycle, on the cycle after acceptance, and changes no state, when its position is:
  - below -1, or
  - at least NUM_PEERS, or
  - -1 with no channel.
- R8: Vector overflow. A registration for a peer that already holds NUM_VECTORS vectors is ignored and raises `ovf_err` for one cycle, on the cycle after acceptance.
- R9: Doorbell destination check. A doorbell whose `db_dest` is greater than `max_peer` produces no notify.
- R10: Doorbell forwarding. In ST_ACTIVE, a doorbell with `db_dest` ≤ `max_peer` and `db_vector` below the destination's vector count produces, one cycle later, `notify_valid`=1 for exactly one cycle, together with `notify_dest`=`db_dest` and `notify_vector`=`db_vector`. Any other doorbell produces `notify_valid`=0.
- R11: Same-cycle ordering. A doorbell offered in the same cycle as an accepted message is judged against the table and `max_peer` as they were before that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Membership message offered |
| msg_ready | output | 1 | Message accepted this cycle when high (low during the sweep) |
| msg_pos | input | POS_W | Signed peer position of the message |
| msg_has_handle | input | 1 | Message carries a notification channel |
| db_valid | input | 1 | Doorbell request offered |
| db_dest | input | DEST_W | Doorbell destination position |
| db_vector | input | VEC_W | Doorbell vector index |
| notify_valid | output | 1 | One-cycle pulse for a forwarded doorbell |
| notify_dest | output | DEST_W | Destination of the forwarded doorbell |
| notify_vector | output | VEC_W | Vector of the forwarded doorbell |
| self_id | output | POS_W | Signed local identifier, -1 when unassigned |
| max_peer | output | clog2(NUM_PEERS) | Highest active peer position |
| pos_err | output | 1 | One-cycle pulse for a message with an illegal position |
| ovf_err | output | 1 | One-cycle pulse for a registration beyond NUM_VECTORS |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is held low for at least one clock edge.
- NUM_PEERS fits in the positive range of POS_W.
- The doorbell fields are stable while `db_valid` is sampled.

The stimulus changes inputs only on falling edges. It holds reset over several edges and keeps positions within the signed POS_W range. It mixes directed sequences with a long random stream of positions clustered near the low peers, so that each message kind and same-cycle doorbell collisions occur often.

// File: rtl/pdvt_pkg.sv
package pdvt_pkg;

    typedef enum logic {
        ST_CLEAR,
        ST_ACTIVE
    } tbl_state_e;

    typedef enum logic [2:0] {
        MK_NONE,
        MK_IDENT,
        MK_DROP_PEER,
        MK_REGION,
        MK_APPEND,
        MK_FULL,
        MK_BADPOS
    } msg_kind_e;

endpackage

// File: rtl/pdvt_msg_decode.sv
module pdvt_msg_decode
    import pdvt_pkg::*;
#(
    parameter int NUM_PEERS   = 64,
    parameter int NUM_VECTORS = 1,
    parameter int POS_W       = 8,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 1
) (
    input  logic                    accept,
    input  logic signed [POS_W-1:0] msg_pos,
    input  logic                    has_handle,
    input  logic [CNT_W-1:0]        cur_count,
    output msg_kind_e               kind,
    output logic [IDX_W-1:0]        idx
);

    logic in_range;
    logic is_region;

    assign idx       = msg_pos[IDX_W-1:0];
    assign in_range  = (msg_pos >= 0) && (int'(msg_pos) < NUM_PEERS);
    assign is_region = has_handle && (msg_pos == -1);

    always_comb begin
        kind = MK_NONE;
        if (accept) begin
            if (is_region) begin
                kind = MK_REGION;
            end else if (!in_range) begin
                kind = MK_BADPOS;
            end else if (!has_handle) begin
                kind = (cur_count == '0) ? MK_IDENT : MK_DROP_PEER;
            end else if (int'(cur_count) == NUM_VECTORS) begin
                kind = MK_FULL;
            end else begin
                kind = MK_APPEND;
            end
        end
    end

endmodule

// File: rtl/pdvt_vec_table.sv
module pdvt_vec_table
    import pdvt_pkg::*;
#(
    parameter int NUM_PEERS   = 64,
    parameter int NUM_VECTORS = 1,
    parameter int POS_W       = 8,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  msg_kind_e               kind,
    input  logic [IDX_W-1:0]        msg_idx,
    input  logic [IDX_W-1:0]        db_idx,
    output logic                    active,
    output logic [CNT_W-1:0]        msg_count,
    output logic [CNT_W-1:0]        db_count,
    output logic signed [POS_W-1:0] self_id,
    output logic [IDX_W-1:0]        max_peer,
    output logic                    pos_err,
    output logic                    ovf_err
);

    tbl_state_e       state, state_nx;
    logic [IDX_W-1:0] clr_idx;
    logic [CNT_W-1:0] counts [NUM_PEERS];

    assign active    = (state == ST_ACTIVE);
    assign msg_count = counts[msg_idx];
    assign db_count  = counts[db_idx];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR:  if (int'(clr_idx) == NUM_PEERS - 1) state_nx = ST_ACTIVE;
            ST_ACTIVE: state_nx = ST_ACTIVE;
            default:   state_nx = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CLEAR) clr_idx <= clr_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_CLEAR) begin
            counts[clr_idx] <= '0;
        end else begin
            unique case (kind)
                MK_DROP_PEER: counts[msg_idx] <= '0;
                MK_APPEND:    counts[msg_idx] <= counts[msg_idx] + CNT_W'(1);
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            self_id  <= '1;
            max_peer <= '0;
            pos_err  <= 1'b0;
            ovf_err  <= 1'b0;
        end else begin
            pos_err <= 1'b0;
            ovf_err <= 1'b0;
            unique case (kind)
                MK_IDENT:  self_id  <= POS_W'(msg_idx);
                MK_REGION: max_peer <= '0;
                MK_APPEND: if (msg_idx > max_peer) max_peer <= msg_idx;
                MK_FULL:   ovf_err  <= 1'b1;
                MK_BADPOS: pos_err  <= 1'b1;
                default:   ;
            endcase
        end
    end

    // R1
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active) |-> active);

    // R2
    self_id_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(self_id) |-> $past(kind == MK_IDENT));

    // R6
    max_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (max_peer > $past(max_peer)) |-> $past(kind == MK_APPEND));

    // R7
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pos_err, ovf_err}) <= 1);

endmodule

// File: rtl/pdvt_door_check.sv
module pdvt_door_check #(
    parameter int NUM_VECTORS = 1,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 1,
    parameter int DEST_W      = 16,
    parameter int VEC_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              db_valid,
    input  logic [DEST_W-1:0] db_dest,
    input  logic [VEC_W-1:0]  db_vector,
    input  logic [IDX_W-1:0]  max_peer,
    input  logic [CNT_W-1:0]  dest_count,
    output logic              notify_valid,
    output logic [DEST_W-1:0] notify_dest,
    output logic [VEC_W-1:0]  notify_vector
);

    logic dest_ok;
    logic vec_ok;
    logic hit;

    assign dest_ok = (32'(db_dest) <= 32'(max_peer));
    assign vec_ok  = (32'(db_vector) < 32'(dest_count));
    assign hit     = db_valid && active && dest_ok && vec_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_valid  <= 1'b0;
            notify_dest   <= '0;
            notify_vector <= '0;
        end else begin
            notify_valid <= hit;
            if (hit) begin
                notify_dest   <= db_dest;
                notify_vector <= db_vector;
            end
        end
    end

    // R10
    notify_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (32'(notify_vector) < NUM_VECTORS));

    // R9
    notify_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (32'(notify_dest) <= $past(32'(max_peer))));

endmodule

// File: rtl/peer_doorbell_table.sv
module peer_doorbell_table
    import pdvt_pkg::*;
#(
    parameter int NUM_PEERS   = 64,
    parameter int NUM_VECTORS = 1,
    parameter int POS_W       = 8,
    parameter int DEST_W      = 16,
    parameter int VEC_W       = 8,
    localparam int IDX_W      = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
    localparam int CNT_W      = (NUM_VECTORS > 0) ? $clog2(NUM_VECTORS + 1) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msg_valid,
    output logic                    msg_ready,
    input  logic signed [POS_W-1:0] msg_pos,
    input  logic                    msg_has_handle,
    input  logic                    db_valid,
    input  logic [DEST_W-1:0]       db_dest,
    input  logic [VEC_W-1:0]        db_vector,
    output logic                    notify_valid,
    output logic [DEST_W-1:0]       notify_dest,
    output logic [VEC_W-1:0]        notify_vector,
    output logic signed [POS_W-1:0] self_id,
    output logic [IDX_W-1:0]        max_peer,
    output logic                    pos_err,
    output logic                    ovf_err
);

    msg_kind_e        kind;
    logic [IDX_W-1:0] msg_idx;
    logic [CNT_W-1:0] msg_count;
    logic [CNT_W-1:0] db_count;
    logic             active;

    assign msg_ready = active;

    pdvt_msg_decode #(
        .NUM_PEERS(NUM_PEERS), .NUM_VECTORS(NUM_VECTORS),
        .POS_W(POS_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_decode (
        .accept     (msg_valid && active),
        .msg_pos    (msg_pos),
        .has_handle (msg_has_handle),
        .cur_count  (msg_count),
        .kind       (kind),
        .idx        (msg_idx)
    );

    pdvt_vec_table #(
        .NUM_PEERS(NUM_PEERS), .NUM_VECTORS(NUM_VECTORS),
        .POS_W(POS_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .msg_idx   (msg_idx),
        .db_idx    (db_dest[IDX_W-1:0]),
        .active    (active),
        .msg_count (msg_count),
        .db_count  (db_count),
        .self_id   (self_id),
        .max_peer  (max_peer),
        .pos_err   (pos_err),
        .ovf_err   (ovf_err)
    );

    pdvt_door_check #(
        .NUM_VECTORS(NUM_VECTORS), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .DEST_W(DEST_W), .VEC_W(VEC_W)
    ) u_door (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .db_valid      (db_valid),
        .db_dest       (db_dest),
        .db_vector     (db_vector),
        .max_peer      (max_peer),
        .dest_count    (db_count),
        .notify_valid  (notify_valid),
        .notify_dest   (notify_dest),
        .notify_vector (notify_vector)
    );

endmodule

// File: tb/peer_doorbell_table_test.sv
module peer_doorbell_table_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int NV = 3;
    localparam int PW = 8;
    localparam int DW = 16;
    localparam int VW = 8;
    localparam int IW = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 msg_valid = 1'b0;
    logic                 msg_ready;
    logic signed [PW-1:0] msg_pos = '0;
    logic                 msg_has_handle = 1'b0;
    logic                 db_valid = 1'b0;
    logic [DW-1:0]        db_dest = '0;
    logic [VW-1:0]        db_vector = '0;
    logic                 notify_valid;
    logic [DW-1:0]        notify_dest;
    logic [VW-1:0]        notify_vector;
    logic signed [PW-1:0] self_id;
    logic [IW-1:0]        max_peer;
    logic                 pos_err;
    logic                 ovf_err;

    peer_doorbell_table #(
        .NUM_PEERS(NP), .NUM_VECTORS(NV), .POS_W(PW), .DEST_W(DW), .VEC_W(VW)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_pos(msg_pos), .msg_has_handle(msg_has_handle),
        .db_valid(db_valid), .db_dest(db_dest), .db_vector(db_vector),
        .notify_valid(notify_valid), .notify_dest(notify_dest),
        .notify_vector(notify_vector), .self_id(self_id),
        .max_peer(max_peer), .pos_err(pos_err), .ovf_err(ovf_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  cmp_en = 1'b0;

    int  m_cnt [NP];
    int  m_self = -1;
    int  m_max = 0;
    int  m_clr = 0;
    bit  e_nv = 1'b0;
    bit  e_pe = 1'b0;
    bit  e_oe = 1'b0;
    int  e_nd = 0;
    int  e_nvec = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin : model_b
        int p;
        bit act;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) m_cnt[i] = 0;
            m_self = -1;
            m_max  = 0;
            m_clr  = 0;
            e_nv   = 1'b0;
            e_pe   = 1'b0;
            e_oe   = 1'b0;
        end else begin
            act  = (m_clr >= NP);
            e_nv = db_valid && act && (int'(db_dest) <= m_max)
                   && (int'(db_vector) < m_cnt[int'(db_dest)]);
            if (e_nv) begin
                e_nd   = int'(db_dest);
                e_nvec = int'(db_vector);
            end
            e_pe = 1'b0;
            e_oe = 1'b0;
            if (act && msg_valid) begin
                p = int'(msg_pos);
                if (p == -1 && msg_has_handle) m_max = 0;
                else if (p < 0 || p >= NP) e_pe = 1'b1;
                else if (!msg_has_handle) begin
                    if (m_cnt[p] == 0) m_self = p;
                    else m_cnt[p] = 0;
                end else if (m_cnt[p] == NV) e_oe = 1'b1;
                else begin
                    m_cnt[p]++;
                    if (p > m_max) m_max = p;
                end
            end
            if (!act) m_clr++;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check(msg_ready == (m_clr >= NP), "R1 msg_ready", int'(msg_ready), int'(m_clr >= NP));
            check(int'(self_id) == m_self, "R2 self_id", int'(self_id), m_self);
            check(int'(max_peer) == m_max, "R6 max_peer", int'(max_peer), m_max);
            check(notify_valid == e_nv, "R10 notify_valid", int'(notify_valid), int'(e_nv));
            if (e_nv && notify_valid) begin
                check(int'(notify_dest) == e_nd, "R10 notify_dest", int'(notify_dest), e_nd);
                check(int'(notify_vector) == e_nvec, "R10 notify_vector", int'(notify_vector), e_nvec);
            end
            check(pos_err == e_pe, "R7 pos_err", int'(pos_err), int'(e_pe));
            check(ovf_err == e_oe, "R8 ovf_err", int'(ovf_err), int'(e_oe));
        end
    end

    task automatic send(input int p, input bit h);
        @(negedge clk);
        msg_valid      = 1'b1;
        msg_pos        = PW'(p);
        msg_has_handle = h;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic door(input int d, input int v, input bit exp, input string tag);
        @(negedge clk);
        db_valid  = 1'b1;
        db_dest   = DW'(d);
        db_vector = VW'(v);
        @(negedge clk);
        db_valid = 1'b0;
        check(notify_valid == exp, tag, int'(notify_valid), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        check(int'(self_id) == -1, "R1 reset self_id", int'(self_id), -1);
        check(max_peer == '0, "R1 reset max_peer", int'(max_peer), 0);
        check(notify_valid == 1'b0, "R1 reset notify", int'(notify_valid), 0);
        rst_n = 1'b1;

        // offered during the sweep: must be ignored
        send(4, 0);
        door(0, 0, 1'b0, "R1 doorbell during clear");
        check(msg_ready == 1'b0, "R1 ready low in clear", int'(msg_ready), 0);
        while (!msg_ready) @(negedge clk);
        check(int'(self_id) == -1, "R1 message in clear ignored", int'(self_id), -1);

        door(0, 0, 1'b0, "R10 empty peer dropped");
        send(5, 0);
        check(int'(self_id) == 5, "R2 identifier learned", int'(self_id), 5);

        send(3, 1);
        door(3, 0, 1'b1, "R5 first vector index 0");
        door(3, 1, 1'b0, "R5 only one vector so far");
        send(3, 1);
        send(3, 1);
        door(3, 2, 1'b1, "R5 third vector index 2");
        send(3, 1);
        door(3, 3, 1'b0, "R8 overflow not registered");

        send(7, 1);
        check(int'(max_peer) == 7, "R6 max raised", int'(max_peer), 7);
        send(2, 1);
        check(int'(max_peer) == 7, "R6 lower position keeps max", int'(max_peer), 7);
        door(8, 0, 1'b0, "R9 dest above highest");
        door(7, 0, 1'b1, "R10 legal doorbell");

        send(3, 0);
        door(3, 0, 1'b0, "R3 teardown clears count");
        check(int'(self_id) == 5, "R3 teardown keeps identifier", int'(self_id), 5);
        send(3, 0);
        check(int'(self_id) == 3, "R2 identifier after teardown", int'(self_id), 3);

        send(70, 1);
        send(-2, 1);
        send(-1, 0);
        door(7, 0, 1'b1, "R7 bad positions leave table");
        check(int'(max_peer) == 7, "R7 bad positions leave max", int'(max_peer), 7);

        @(negedge clk);
        msg_valid = 1'b1; msg_pos = PW'(7); msg_has_handle = 1'b0;
        db_valid = 1'b1; db_dest = DW'(7); db_vector = '0;
        @(negedge clk);
        msg_valid = 1'b0; db_valid = 1'b0;
        check(notify_valid == 1'b1, "R11 doorbell sees old table", int'(notify_valid), 1);
        door(7, 0, 1'b0, "R11 teardown applied afterwards");

        send(-1, 1);
        check(int'(max_peer) == 0, "R4 region resets max", int'(max_peer), 0);
        door(2, 0, 1'b0, "R4 dest above reset highest");
        send(2, 1);
        door(2, 1, 1'b1, "R4 region keeps counts");

        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            msg_valid      = ($urandom_range(0, 1) == 1);
            msg_pos        = ($urandom_range(0, 7) == 0) ? PW'(int'($urandom_range(0, 75)) - 2)
                                                          : PW'(int'($urandom_range(0, 8)) - 1);
            msg_has_handle = ($urandom_range(0, 3) != 0);
            db_valid       = ($urandom_range(0, 1) == 1);
            db_dest        = DW'($urandom_range(0, 9));
            db_vector      = VW'($urandom_range(0, 3));
        end
        @(negedge clk);
        msg_valid = 1'b0;
        db_valid  = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule